// File: doc/BRIEF.md
# Timer Output Compare Unit

This block watches the running value of a timer counter and reports when it equals a programmable compare value. The equality result goes out at once as a match signal for a downstream waveform generator. A registered compare flag records the event. When its interrupt is enabled, the flag raises an interrupt request. The flag clears in one of two ways: when the interrupt controller acknowledges the request, or when software writes a one to the flag's clear port.

The flag only advances on cycles where the timer tick enable is high. A prescaled timer therefore records each match once per timer step and not once per system clock. A match seen on a ticking cycle sets the flag one cycle later.

A unit built with the TOP-defining option can also offer its compare value as the counter's wrap limit. The limit then sets both the counter's resolution and the waveform period. The block also reports when the counter sits at that limit and when it sits at zero, so the waveform generator can handle the extreme values.

Top module: `ocu_unit`

## Requirements
- R1: The compare value register resets to 0 and loads `cmp_wr_data` on the clock edge where `cmp_wr_en` is high. `match` is high in exactly those cycles where `count` equals the stored compare value. It follows `count` combinationally.
- R2: If `match` and `tick` are both high at a clock edge, `flag` is high after that edge. The flag is never set at an edge where `tick` is low, even when `match` is high.
- R3: `irq` is high exactly when `flag` is high and `irq_en` is high.
- R4: If `irq_ack` is high at an edge, and no set happens at that same edge, `flag` is low after the edge.
- R5: A clear write is a clock edge where `flag_wr` is high. If `flag_wr_data` is 1 at that edge, `flag` is low after it, unless a set happens at the same edge. If `flag_wr_data` is 0, the flag keeps its value.
- R6: If a set condition (R2) and a clear (R4 or R5) arrive at the same edge, `flag` is high after the edge.
- R7: With `TOP_CAPABLE`=1 and `top_sel` high, `top_value` equals the stored compare value. Otherwise `top_value` is all ones. `at_top` is high when `count` equals `top_value`, and `at_bottom` is high when `count` is 0.
- R8: After synchronous reset, `flag` and `irq` are low and the compare value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer step enable for the flag logic |
| count | input | W | Current timer counter value |
| cmp_wr_en | input | 1 | Compare register write strobe |
| cmp_wr_data | input | W | Compare register write data |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Interrupt serviced, clears the flag |
| flag_wr | input | 1 | Flag write strobe |
| flag_wr_data | input | 1 | Flag write data; 1 clears the flag |
| top_sel | input | 1 | Use the compare value as the counter limit |
| match | output | 1 | Counter equals compare value |
| cmp_value | output | W | Stored compare value |
| flag | output | 1 | Compare flag |
| irq | output | 1 | Interrupt request |
| top_value | output | W | Counter wrap limit |
| at_top | output | 1 | Counter equals the limit |
| at_bottom | output | 1 | Counter is zero |

## Verification
The hardest case to reach is the edge where a match on a ticking cycle meets an acknowledge or a one-write. In normal use these come from independent agents, and they seldom land on the same edge. The bench holds the counter on the compare value and raises `tick`, `irq_ack` and the clear write together for a single edge. It also holds a match with `tick` low for several edges, to show that prescaled cycles leave the flag alone. Separately, an exhaustive sweep of every counter value against every compare value, on a 4-bit build, covers match, limit and zero detection.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

    typedef struct packed {
        logic set_req;
        logic ack_clr;
        logic sw_clr;
    } flag_evt_t;

    typedef enum logic [1:0] {
        FL_HOLD  = 2'd0,
        FL_SET   = 2'd1,
        FL_CLEAR = 2'd2
    } flag_act_t;

    // Setting wins over any clear arriving on the same edge.
    function automatic flag_act_t resolve_flag(flag_evt_t e);
        if (e.set_req)
            return FL_SET;
        else if (e.ack_clr || e.sw_clr)
            return FL_CLEAR;
        else
            return FL_HOLD;
    endfunction

endpackage

// File: rtl/ocu_cmp_reg.sv
module ocu_cmp_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] count,
    output logic [W-1:0] cmp_q,
    output logic         match
);

    always_ff @(posedge clk) begin
        if (rst)
            cmp_q <= '0;
        else if (wr_en)
            cmp_q <= wr_data;
    end

    assign match = (count == cmp_q);

    p_cmp_load_r1: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cmp_q == $past(wr_data)))
        else $error("compare register load failed");

    p_cmp_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cmp_q))
        else $error("compare register changed without write");

endmodule

// File: rtl/ocu_flag.sv
module ocu_flag
    import ocu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic match,
    input  logic irq_ack,
    input  logic flag_wr,
    input  logic flag_wr_data,
    input  logic irq_en,
    output logic flag,
    output logic irq
);

    flag_evt_t evt;
    flag_act_t act;

    always_comb begin
        evt.set_req = tick & match;
        evt.ack_clr = irq_ack;
        evt.sw_clr  = flag_wr & flag_wr_data;
        act         = resolve_flag(evt);
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else begin
            case (act)
                FL_SET:   flag <= 1'b1;
                FL_CLEAR: flag <= 1'b0;
                default:  flag <= flag;
            endcase
        end
    end

    assign irq = flag & irq_en;

    p_flag_set_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && match) |=> flag)
        else $error("flag not set after ticking match");

    p_no_untimed_set_r2: assert property (@(posedge clk) disable iff (rst)
        (!flag && !(tick && match)) |=> !flag)
        else $error("flag set without ticking match");

    p_ack_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !(tick && match)) |=> !flag)
        else $error("acknowledge did not clear flag");

    p_w1c_r5: assert property (@(posedge clk) disable iff (rst)
        (flag_wr && flag_wr_data && !(tick && match)) |=> !flag)
        else $error("write-one did not clear flag");

    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && match && (irq_ack || flag_wr)) |=> flag)
        else $error("clear overrode simultaneous set");

endmodule

// File: rtl/ocu_limits.sv
module ocu_limits #(
    parameter int W           = 16,
    parameter bit TOP_CAPABLE = 1'b1
) (
    input  logic [W-1:0] count,
    input  logic [W-1:0] cmp_q,
    input  logic         top_sel,
    output logic [W-1:0] top_value,
    output logic         at_top,
    output logic         at_bottom
);

    localparam logic [W-1:0] FULL_SCALE = {W{1'b1}};

    logic use_cmp;
    assign use_cmp   = TOP_CAPABLE & top_sel;
    assign top_value = use_cmp ? cmp_q : FULL_SCALE;
    assign at_top    = (count == top_value);
    assign at_bottom = (count == '0);

    always_comb begin
        if (!top_sel)
            a_full_scale_r7: assert (top_value == FULL_SCALE)
                else $error("limit not full scale when unselected");
    end

endmodule

// File: rtl/ocu_unit.sv
module ocu_unit #(
    parameter int W           = 16,
    parameter bit TOP_CAPABLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] count,
    input  logic         cmp_wr_en,
    input  logic [W-1:0] cmp_wr_data,
    input  logic         irq_en,
    input  logic         irq_ack,
    input  logic         flag_wr,
    input  logic         flag_wr_data,
    input  logic         top_sel,
    output logic         match,
    output logic [W-1:0] cmp_value,
    output logic         flag,
    output logic         irq,
    output logic [W-1:0] top_value,
    output logic         at_top,
    output logic         at_bottom
);

    ocu_cmp_reg #(.W(W)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cmp_wr_en),
        .wr_data (cmp_wr_data),
        .count   (count),
        .cmp_q   (cmp_value),
        .match   (match)
    );

    ocu_flag u_flag (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .match        (match),
        .irq_ack      (irq_ack),
        .flag_wr      (flag_wr),
        .flag_wr_data (flag_wr_data),
        .irq_en       (irq_en),
        .flag         (flag),
        .irq          (irq)
    );

    ocu_limits #(.W(W), .TOP_CAPABLE(TOP_CAPABLE)) u_lim (
        .count     (count),
        .cmp_q     (cmp_value),
        .top_sel   (top_sel),
        .top_value (top_value),
        .at_top    (at_top),
        .at_bottom (at_bottom)
    );

    p_irq_gate_r3: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag && irq_en))
        else $error("irq without enabled flag");

    p_reset_r8: assert property (@(posedge clk)
        rst |=> (!flag && cmp_value == '0))
        else $error("reset state wrong");

endmodule

// File: tb/ocu_unit_test.sv
module ocu_unit_test;

    localparam int W = 4;
    localparam int N = 1 << W;

    logic         clk = 1'b0;
    logic         rst;
    logic         tick;
    logic [W-1:0] count;
    logic         cmp_wr_en;
    logic [W-1:0] cmp_wr_data;
    logic         irq_en, irq_ack, flag_wr, flag_wr_data, top_sel;
    logic         match, flag, irq, at_top, at_bottom;
    logic [W-1:0] cmp_value, top_value;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ocu_unit #(.W(W), .TOP_CAPABLE(1'b1)) uut (
        .clk(clk), .rst(rst), .tick(tick), .count(count),
        .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
        .irq_en(irq_en), .irq_ack(irq_ack), .flag_wr(flag_wr),
        .flag_wr_data(flag_wr_data), .top_sel(top_sel),
        .match(match), .cmp_value(cmp_value), .flag(flag), .irq(irq),
        .top_value(top_value), .at_top(at_top), .at_bottom(at_bottom)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive at the falling edge, pass one rising edge, sample 1 ns after it.
    task automatic step();
        @(posedge clk);
        #1;
        tick = 0; cmp_wr_en = 0; irq_ack = 0; flag_wr = 0; flag_wr_data = 0;
    endtask

    task automatic write_cmp(input logic [W-1:0] v);
        @(negedge clk);
        cmp_wr_en = 1; cmp_wr_data = v;
        step();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; tick = 0; count = '0; cmp_wr_en = 0; cmp_wr_data = '0;
        irq_en = 0; irq_ack = 0; flag_wr = 0; flag_wr_data = 0; top_sel = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R8 reset state
        check("R8 flag", int'(flag), 0);
        check("R8 irq", int'(irq), 0);
        check("R8 cmp", int'(cmp_value), 0);

        // R1, R7 exhaustive sweep; tick low so R2 says the flag stays clear
        for (int c = 0; c < N; c++) begin
            write_cmp(W'(c));
            check("R1 load", int'(cmp_value), c);
            for (int n = 0; n < N; n++) begin
                for (int s = 0; s < 2; s++) begin
                    @(negedge clk);
                    count = W'(n); top_sel = s[0];
                    #1;
                    check("R1 match", int'(match), int'(n == c));
                    check("R7 top", int'(top_value), (s == 1) ? c : N - 1);
                    check("R7 at_top", int'(at_top), int'(n == ((s == 1) ? c : N - 1)));
                    check("R7 at_bottom", int'(at_bottom), int'(n == 0));
                end
            end
            step();
            check("R2 no tick", int'(flag), 0);
        end
        top_sel = 0;

        // R2 held match with tick low for several edges
        write_cmp(4'd5);
        @(negedge clk); count = 4'd5;
        for (int k = 0; k < 4; k++) begin
            step();
            check("R2 untimed match", int'(flag), 0);
        end
        // R2 set one edge after ticking match
        @(negedge clk); tick = 1;
        #1 check("R2 not same cycle", int'(flag), 0);
        step();
        check("R2 set", int'(flag), 1);
        // R3
        #1 check("R3 disabled", int'(irq), 0);
        irq_en = 1;
        #1 check("R3 enabled", int'(irq), 1);

        // R5 write zero ignored, then write one clears
        @(negedge clk); count = 4'd6; flag_wr = 1; flag_wr_data = 0;
        step();
        check("R5 write zero", int'(flag), 1);
        @(negedge clk); flag_wr = 1; flag_wr_data = 1;
        step();
        check("R5 write one", int'(flag), 0);
        check("R3 follows flag", int'(irq), 0);

        // R4 acknowledge clears
        @(negedge clk); count = 4'd5; tick = 1;
        step();
        check("R2 reset again", int'(flag), 1);
        @(negedge clk); count = 4'd7; irq_ack = 1; tick = 1;
        step();
        check("R4 ack clear", int'(flag), 0);

        // R6 set beats simultaneous clears
        @(negedge clk); count = 4'd5; tick = 1; irq_ack = 1;
        step();
        check("R6 vs ack", int'(flag), 1);
        @(negedge clk); tick = 1; flag_wr = 1; flag_wr_data = 1; irq_ack = 1;
        step();
        check("R6 vs write", int'(flag), 1);

        // R8 reset mid-run
        @(negedge clk); rst = 1;
        step();
        rst = 0;
        check("R8 flag after reset", int'(flag), 0);
        check("R8 cmp after reset", int'(cmp_value), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule